// File: doc/BRIEF.md
# Event Status Flag Register

This block is an 8-bit status register on a simple register bus. It records three hardware events as sticky flags. Two of the events are end-of-conversion pulses from converter channels A and B, each raised once the channel's result is in its result register. The third is a local comparison that detects when a free-running counter becomes equal to a compare value.

Software reads the register to see which events have happened. Clearing a flag takes two steps. First, a bus read must return that flag as 1. After that, a bus write must carry 0 in the flag's bit position. A write of 0 without such a read, a write of 1, and any access while the select line is low all leave the flags unchanged. This protects against a flag being lost when it is raised between software's last look at the register and its clear.

Top module: `evt_flag_reg`

## Requirements
- R1: After a synchronous active-low reset every flag is 0 and the register reads as 0x00.
- R2: While `sel` is high, `rd_data` shows the register: bit 6 is the channel B flag, bit 5 is the channel A flag, bit 4 is the match flag, and bits 7 and 3..0 read 0. While `sel` is low, `rd_data` is 0x00. Presenting data does not need `rd_stb`.
- R3: A one-cycle pulse on `done_a` or `done_b` sets the matching flag at the next rising clock edge. The flag stays 1 until a qualified clear.
- R4: The match flag sets at the edge where `cnt_val` equals `cmp_val` while it did not equal it in the previous cycle. It does not set again while the two stay equal. It sets again when equality returns after a mismatch.
- R5: A read (`sel` and `rd_stb`) that returns a flag as 1 arms that flag. A later write (`sel` and `wr_stb`) that carries 0 in the flag's bit clears the flag and disarms it.
- R6: A write of 0 to a flag that is not armed has no effect. A read that returns a flag as 0 does not arm it. Reads and writes while `sel` is low have no effect.
- R7: Writing 1 to a flag bit has no effect. Writes to bits 7 and 3..0 have no effect.
- R8: When a set event and a qualified clear fall in the same cycle, the flag stays 1 and is disarmed, so a later write of 0 alone does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Register select |
| rd_stb | input | 1 | Read strobe, qualified by `sel` |
| wr_stb | input | 1 | Write strobe, qualified by `sel` |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| done_a | input | 1 | Channel A end-of-conversion pulse |
| done_b | input | 1 | Channel B end-of-conversion pulse |
| cnt_val | input | CNT_W | Free-running counter value |
| cmp_val | input | CNT_W | Compare value for the match flag |

## Verification
The flag logic is driven with these patterns:
- plain writes of 0 with no read before them;
- a read followed by a write of 0;
- reads that return a flag as 0;
- accesses with `sel` low;
- writes of all ones;
- a set event in the same cycle as a qualified clear.

Together these separate a correct two-step clear from three faulty designs: one that clears on any write of 0, one that arms without checking the value read, and one that lets the clear win over a new event.

The counter inputs are driven through these patterns:
- unequal values;
- a transition to equality;
- a held equality;
- a mismatch followed by a return to equality.

These show that the match flag is edge-triggered, and that after a clear it is not raised again while the counter and compare value stay equal.

A final set of directed steps covers two cases. The first is an event and an arming read in the same cycle. The second is a reset taken while flags are set.

// File: rtl/evt_flag_pkg.sv
// Package: evt_flag_pkg
// Shared layout constants for the event status flag register.
// Assumes an 8-bit register with the flags in adjacent bits.
package evt_flag_pkg;
    localparam int REG_W    = 8;
    localparam int N_FLAGS  = 3;
    // Flag index i sits at bit FLAG_LSB + i.
    localparam int FLAG_LSB = 4;
    localparam int IDX_MTCH = 0;
    localparam int IDX_CHA  = 1;
    localparam int IDX_CHB  = 2;
endpackage

// File: rtl/evt_flag_cell.sv
// Module: evt_flag_cell
// One sticky flag with a private arm bit. An arming read sets the arm bit
// when the flag reads as 1. A later clear request clears the flag only if
// it is armed. A set event has priority over a clear and disarms the flag.
// Assumes the strobe inputs are already qualified by the register select.
module evt_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic arm_rd_i,
    input  logic clr_req_i,
    output logic flag_o
);
    logic flag_q;
    logic armed_q;

    // Update the flag and the arm bit: set first, then a qualified clear, then arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (set_i) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (clr_req_i && armed_q) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (arm_rd_i && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q); // R3
    AST_SET_WINS_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_req_i) |=> (flag_q && !armed_q)); // R8
    AST_QUAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && clr_req_i && !set_i) |=> !flag_q); // R5
    AST_UNARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !armed_q && !set_i) |=> flag_q); // R6
    AST_ARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> flag_q); // R5
endmodule

// File: rtl/evt_match_det.sv
// Module: evt_match_det
// Compares the counter with the compare value in every cycle. It gives a
// one-cycle pulse in the first cycle the two are equal.
// Assumes both values are synchronous to clk.
module evt_match_det #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             hit_o
);
    logic eq;
    logic eq_q;

    // Present equality of counter and compare value.
    assign eq = (cnt_i == cmp_i);

    // Remember last cycle's equality for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq;
    end

    assign hit_o = eq && !eq_q;

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o); // R4
endmodule

// File: rtl/evt_flag_reg.sv
// Module: evt_flag_reg
// Event status flag register. It holds a channel B done flag, a channel A
// done flag and a counter match flag. A flag clears only when a read saw
// it set and a later write carries 0 in its bit.
// Assumes event pulses are synchronous to clk and one cycle wide.
module evt_flag_reg
    import evt_flag_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             done_a,
    input  logic             done_b,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cmp_val
);
    logic               match_hit;
    logic [N_FLAGS-1:0] set_vec;
    logic [N_FLAGS-1:0] flags;
    logic               rd_hit;
    logic               wr_hit;

    evt_match_det #(.CNT_W(CNT_W)) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_i (cnt_val),
        .cmp_i (cmp_val),
        .hit_o (match_hit)
    );

    // Gather the event sources in flag index order.
    always_comb begin
        set_vec           = '0;
        set_vec[IDX_MTCH] = match_hit;
        set_vec[IDX_CHA]  = done_a;
        set_vec[IDX_CHB]  = done_b;
    end

    assign rd_hit = sel && rd_stb;
    assign wr_hit = sel && wr_stb;

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        evt_flag_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_vec[i]),
            .arm_rd_i  (rd_hit),
            .clr_req_i (wr_hit && !wr_data[FLAG_LSB+i]),
            .flag_o    (flags[i])
        );
    end

    // Place the flags in the register image; reserved bits and a deselected bus read 0.
    always_comb begin
        rd_data = '0;
        if (sel) rd_data[FLAG_LSB +: N_FLAGS] = flags;
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (flags == '0)); // R1
    AST_DESEL_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && (set_vec == '0)) |=> (flags == $past(flags))); // R6
endmodule

// File: tb/sim_evt_flag_reg.sv
module sim_evt_flag_reg;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel, rd_stb, wr_stb, done_a, done_b;
    logic [7:0] wr_data, rd_data, cnt_val, cmp_val;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    evt_flag_reg #(.CNT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_data(rd_data), .done_a(done_a), .done_b(done_b),
        .cnt_val(cnt_val), .cmp_val(cmp_val)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       s, ea, eb;
        logic [7:0] cnt, cmp;
        logic       rd, wr;
        logic [7:0] wd;
        logic [2:0] ex;   // expected {B, A, match} = bits 6,5,4
    } vec_t;

    localparam int NV = 29;
    localparam vec_t TBL [NV] = '{
        '{4'd2, 1'b1,1'b0,1'b0, 8'd1,8'd5, 1'b0,1'b0, 8'h00, 3'b000}, // R2 idle
        '{4'd3, 1'b1,1'b1,1'b0, 8'd1,8'd5, 1'b0,1'b0, 8'h00, 3'b010}, // R3 done_a
        '{4'd6, 1'b1,1'b0,1'b0, 8'd1,8'd5, 1'b0,1'b1, 8'h00, 3'b010}, // R6 write 0 unarmed
        '{4'd5, 1'b1,1'b0,1'b0, 8'd1,8'd5, 1'b1,1'b0, 8'h00, 3'b010}, // R5 arm read
        '{4'd7, 1'b1,1'b0,1'b0, 8'd1,8'd5, 1'b0,1'b1, 8'hFF, 3'b010}, // R7 write ones
        '{4'd5, 1'b1,1'b0,1'b0, 8'd1,8'd5, 1'b0,1'b1, 8'h00, 3'b000}, // R5 qualified clear
        '{4'd3, 1'b1,1'b0,1'b1, 8'd1,8'd5, 1'b0,1'b0, 8'h00, 3'b100}, // R3 done_b
        '{4'd6, 1'b0,1'b0,1'b0, 8'd1,8'd5, 1'b1,1'b0, 8'h00, 3'b100}, // R6 deselected read
        '{4'd6, 1'b1,1'b0,1'b0, 8'd1,8'd5, 1'b0,1'b1, 8'h00, 3'b100}, // R6 not armed by it
        '{4'd5, 1'b1,1'b0,1'b0, 8'd1,8'd5, 1'b1,1'b0, 8'h00, 3'b100}, // R5 arm B
        '{4'd6, 1'b0,1'b0,1'b0, 8'd1,8'd5, 1'b0,1'b1, 8'h00, 3'b100}, // R6 deselected write
        '{4'd5, 1'b1,1'b1,1'b0, 8'd1,8'd5, 1'b0,1'b1, 8'h00, 3'b010}, // R5 B clears, A sets
        '{4'd5, 1'b1,1'b0,1'b0, 8'd1,8'd5, 1'b1,1'b0, 8'h00, 3'b010}, // R5 arm A
        '{4'd8, 1'b1,1'b1,1'b0, 8'd1,8'd5, 1'b0,1'b1, 8'h00, 3'b010}, // R8 set beats clear
        '{4'd8, 1'b1,1'b0,1'b0, 8'd1,8'd5, 1'b0,1'b1, 8'h00, 3'b010}, // R8 disarmed
        '{4'd4, 1'b1,1'b0,1'b0, 8'd5,8'd5, 1'b0,1'b0, 8'h00, 3'b011}, // R4 becomes equal
        '{4'd4, 1'b1,1'b0,1'b0, 8'd5,8'd5, 1'b0,1'b0, 8'h00, 3'b011}, // R4 hold
        '{4'd5, 1'b1,1'b0,1'b0, 8'd5,8'd5, 1'b1,1'b0, 8'h00, 3'b011}, // R5 arm A, match
        '{4'd5, 1'b1,1'b0,1'b0, 8'd5,8'd5, 1'b0,1'b1, 8'hEF, 3'b010}, // R5 clear match only
        '{4'd4, 1'b1,1'b0,1'b0, 8'd5,8'd5, 1'b0,1'b0, 8'h00, 3'b010}, // R4 no retrigger
        '{4'd4, 1'b1,1'b0,1'b0, 8'd6,8'd5, 1'b0,1'b0, 8'h00, 3'b010}, // R4 mismatch
        '{4'd4, 1'b1,1'b0,1'b0, 8'd5,8'd5, 1'b0,1'b0, 8'h00, 3'b011}, // R4 equal again
        '{4'd5, 1'b1,1'b0,1'b0, 8'd5,8'd5, 1'b1,1'b0, 8'h00, 3'b011}, // R5 arm both
        '{4'd5, 1'b1,1'b0,1'b0, 8'd1,8'd5, 1'b0,1'b1, 8'h00, 3'b000}, // R5 clear both
        '{4'd6, 1'b1,1'b0,1'b0, 8'd1,8'd5, 1'b1,1'b0, 8'h00, 3'b000}, // R6 read of zero
        '{4'd3, 1'b1,1'b0,1'b1, 8'd1,8'd5, 1'b0,1'b0, 8'h00, 3'b100}, // R3 done_b
        '{4'd6, 1'b1,1'b0,1'b0, 8'd1,8'd5, 1'b0,1'b1, 8'h00, 3'b100}, // R6 zero-read not armed
        '{4'd5, 1'b1,1'b1,1'b0, 8'd1,8'd5, 1'b1,1'b0, 8'h00, 3'b110}, // R5 arm B, A sets
        '{4'd5, 1'b1,1'b0,1'b0, 8'd1,8'd5, 1'b0,1'b1, 8'h00, 3'b010}  // R5 only B clears
    };

    task automatic check(input string tag, input logic [7:0] exp);
        n_chk++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=%02h expected=%02h", tag, rd_data, exp);
        end
    endtask

    task automatic idle_bus();
        sel = 1'b1; rd_stb = 1'b0; wr_stb = 1'b0; wr_data = 8'h00;
        done_a = 1'b0; done_b = 1'b0;
    endtask

    task automatic run();
        rst_n = 1'b0; idle_bus(); cnt_val = 8'd1; cmp_val = 8'd5;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1 check("R1 reset value", 8'h00);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            sel = TBL[i].s; done_a = TBL[i].ea; done_b = TBL[i].eb;
            cnt_val = TBL[i].cnt; cmp_val = TBL[i].cmp;
            rd_stb = TBL[i].rd; wr_stb = TBL[i].wr; wr_data = TBL[i].wd;
            @(negedge clk);
            sel = 1'b1; rd_stb = 1'b0; wr_stb = 1'b0; done_a = 1'b0; done_b = 1'b0;
            #1 check($sformatf("R%0d vector %0d", TBL[i].req, i), {1'b0, TBL[i].ex, 4'b0000});
        end
        // R2: deselected bus reads zero though flag A is set
        sel = 1'b0;
        #1 check("R2 deselected read", 8'h00);
        sel = 1'b1;
        // R1: reset taken while flags are set
        done_a = 1'b1; done_b = 1'b1; cnt_val = 8'd9; cmp_val = 8'd9;
        @(negedge clk); done_a = 1'b0; done_b = 1'b0;
        #1 check("R3 all set before reset", 8'h70);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; cnt_val = 8'd1;
        #1 check("R1 reset clears flags", 8'h00);
    endtask

    initial begin
        fork
            run();
            begin
                #200000;
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual=hung expected=complete");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule